// File: doc/BRIEF.md
# Receive Descriptor Write-back Engine

This engine moves received Ethernet frames from a byte-wide MAC receive stream into system memory. It walks a linked list of receive descriptors. Each descriptor is four 32-bit words: a status/length word at offset 0, a buffer address at offset 4, an unused word at offset 8 and a link to the next descriptor at offset 12. For each descriptor that the engine owns, it reads the buffer and link words. It then stores the frame bytes, including the 4 CRC bytes, into the buffer as 32-bit words. Once the frame is stored, it writes the status/length word back, which hands the descriptor to the CPU, and moves on to the linked descriptor.

Software places the list head on `cfg_list_base` and raises `cfg_rx_en`. The engine then runs without any further prompting. If the engine reaches a descriptor it does not own, it raises a "no descriptor" flag and discards incoming frames. A pulse on `rx_poll` makes it fetch the descriptor again at the next frame boundary. Sticky status flags are cleared by writing ones to `sta_clr`. The interrupt is the OR of the status flags that are enabled in `irq_en`. Address filtering and CRC checking are not part of this block: every frame is accepted.

Top module: `rxwb_engine`

## Requirements
- R1: After reset, `cur_desc`, `rx_status` and `rx_irq` are all zero, and `rx_ready` is low.
- R2: On the first cycle with `cfg_rx_en` high after reset, `cur_desc` is loaded from `cfg_list_base`. A descriptor is used only when bits 31:30 of its status word equal 2'b10 (engine-owned).
- R3: The status word written back has bits 31:30 = 2'b00 (CPU-owned) and bit 20 set (good frame). Bit 16 equals `irq_en[0]`. Bits 15:0 hold the byte count received, CRC included.
- R4: Frame bytes are packed little-endian into 32-bit words. Words go to consecutive addresses starting at the buffer address, and a final partial word has its upper bytes zero.
- R5: When the write-back completes, `cur_desc` takes the link word (offset 12) of the descriptor just finished. It changes at no other time once loaded.
- R6: A stored frame sets status bit 0 (receive interrupt) and bit 4 (good frame). The first stored byte of a frame sets bit 9 (early notice).
- R7: A frame longer than MAX_FRAME (1518) bytes, counted with CRC, is dropped when `cfg_long_ok` is low: the descriptor is not written back and `cur_desc` does not move. With `cfg_long_ok` high, the frame is stored in full, and both descriptor bit 19 and status bit 3 are set.
- R8: A fetched descriptor that is not engine-owned sets status bits 10 and 0. The engine then accepts and discards frames without writing memory, until an `rx_poll` pulse is seen at a frame boundary.
- R9: An `rx_poll` pulse while a frame is being stored has no effect on the stored data or on the write-back.
- R10: `rx_irq` is high exactly when some bit is set in both `rx_status` and `irq_en`. A one in `sta_clr` clears the matching status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_list_base | input | 32 | Address of the first descriptor |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_long_ok | input | 1 | Store frames longer than MAX_FRAME |
| rx_poll | input | 1 | Poll strobe: refetch after a descriptor shortage |
| irq_en | input | 16 | Per-bit interrupt enable for `rx_status` |
| sta_clr | input | 16 | Write-one-to-clear for `rx_status` |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the last byte (CRC included) of a frame |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high |
| cur_desc | output | 32 | Address of the current descriptor |
| rx_status | output | 16 | Sticky status flags |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Two events can fall in the same cycle: the status flags are set by the engine while software clears them, and a poll pulse arrives while a frame is being stored. The bench pulses `rx_poll` in the middle of a frame and then compares the stored buffer and the written-back word with its model. It also applies `sta_clr` between frames and compares `rx_status` against its own expected flag set. Memory is stalled on every third cycle, so that word writes and byte acceptance overlap in varying phase. The 1518/1519-byte boundary is probed with `cfg_long_ok` low, and a 1600-byte frame with it high.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 16;
    localparam int STA_W     = 16;

    localparam int STA_INTR   = 0;
    localparam int STA_PTLE   = 3;
    localparam int STA_GOOD   = 4;
    localparam int STA_EARLY  = 9;
    localparam int STA_NODESC = 10;

    localparam logic [1:0] OWN_ENGINE = 2'b10;
    localparam logic [1:0] OWN_CPU    = 2'b00;

    localparam logic [WORD_W-1:0] OFS_BUF  = 32'd4;
    localparam logic [WORD_W-1:0] OFS_NEXT = 32'd12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_STAT,
        ST_GET_BUF,
        ST_GET_NEXT,
        ST_RECV,
        ST_PUT_STAT,
        ST_NODESC
    } wb_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] buf_addr;
        logic [WORD_W-1:0] next_addr;
    } desc_ctx_t;

    function automatic logic [WORD_W-1:0] wb_word(input logic [LEN_W-1:0] len,
                                                  input logic long_f,
                                                  input logic intr_f);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[31:30]   = OWN_CPU;
        w[20]      = 1'b1;
        w[19]      = long_f;
        w[16]      = intr_f;
        w[LEN_W-1:0] = len;
        return w;
    endfunction
endpackage

// File: rtl/rxwb_packer.sv
module rxwb_packer
    import rxwb_pkg::*;
#(
    parameter int MAX_FRAME = 1518
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [7:0]        byte_in,
    input  logic              last_in,
    input  logic              flush,
    output logic [WORD_W-1:0] word_o,
    output logic              pend_o,
    output logic              plast_o,
    output logic [LEN_W-1:0]  count_o,
    output logic              over_o
);
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] word_q;
    logic              pend_q;
    logic              plast_q;
    logic [LEN_W-1:0]  count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q  <= '0;
            word_q  <= '0;
            pend_q  <= 1'b0;
            plast_q <= 1'b0;
            count_q <= '0;
        end else if (flush) begin
            lane_q  <= '0;
            word_q  <= '0;
            pend_q  <= 1'b0;
            plast_q <= 1'b0;
            if (plast_q) count_q <= '0;
        end else if (take) begin
            word_q[{lane_q, 3'b000} +: 8] <= byte_in;
            lane_q  <= lane_q + 1'b1;
            if (count_q != '1) count_q <= count_q + 1'b1;
            if (lane_q == LANE_W'(LANES - 1) || last_in) pend_q <= 1'b1;
            plast_q <= last_in;
        end
    end

    assign word_o  = word_q;
    assign pend_o  = pend_q;
    assign plast_o = plast_q;
    assign count_o = count_q;
    assign over_o  = (32'(count_q) > MAX_FRAME);
endmodule

// File: rtl/rxwb_status.sv
module rxwb_status
    import rxwb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STA_W-1:0] set_i,
    input  logic [STA_W-1:0] clr_i,
    input  logic [STA_W-1:0] en_i,
    output logic [STA_W-1:0] sta_o,
    output logic             irq_o
);
    logic [STA_W-1:0] sta_q;

    always_ff @(posedge clk) begin
        if (rst) sta_q <= '0;
        else     sta_q <= (sta_q & ~clr_i) | set_i;
    end

    assign sta_o = sta_q;
    assign irq_o = |(sta_q & en_i);
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
    import rxwb_pkg::*;
#(
    parameter int MAX_FRAME = 1518
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cfg_list_base,
    input  logic              cfg_rx_en,
    input  logic              cfg_long_ok,
    input  logic              rx_poll,
    input  logic [STA_W-1:0]  irq_en,
    input  logic [STA_W-1:0]  sta_clr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] cur_desc,
    output logic [STA_W-1:0]  rx_status,
    output logic              rx_irq
);
    wb_state_t         st_q;
    desc_ctx_t         ctx_q;
    logic [WORD_W-1:0] cur_q;
    logic [WORD_W-1:0] off_q;
    logic [LEN_W-1:0]  len_q;
    logic              ptle_q;
    logic              started_q;
    logic              drop_q;
    logic              mid_q;
    logic              poll_q;

    logic [WORD_W-1:0] pk_word;
    logic              pk_pend;
    logic              pk_plast;
    logic [LEN_W-1:0]  pk_count;
    logic              pk_over;
    logic              pk_take;
    logic              pk_flush;
    logic              drop_now;
    logic              take;
    logic [STA_W-1:0]  sta_set;

    assign rx_ready = ((st_q == ST_RECV) && !pk_pend) || (st_q == ST_NODESC);
    assign take     = rx_valid && rx_ready;
    assign pk_take  = take && (st_q == ST_RECV);
    assign drop_now = drop_q || (pk_over && !cfg_long_ok);
    assign pk_flush = (st_q == ST_RECV) && pk_pend && (drop_now || mem_ready);

    rxwb_packer #(.MAX_FRAME(MAX_FRAME)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .take    (pk_take),
        .byte_in (rx_data),
        .last_in (rx_last),
        .flush   (pk_flush),
        .word_o  (pk_word),
        .pend_o  (pk_pend),
        .plast_o (pk_plast),
        .count_o (pk_count),
        .over_o  (pk_over)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        unique case (st_q)
            ST_GET_STAT: mem_req = 1'b1;
            ST_GET_BUF: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + OFS_BUF;
            end
            ST_GET_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + OFS_NEXT;
            end
            ST_RECV: begin
                mem_req   = pk_pend && !drop_now;
                mem_we    = 1'b1;
                mem_addr  = ctx_q.buf_addr + off_q;
                mem_wdata = pk_word;
            end
            ST_PUT_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wb_word(len_q, ptle_q, irq_en[STA_INTR]);
            end
            default: ;
        endcase
    end

    always_comb begin
        sta_set = '0;
        if (st_q == ST_GET_STAT && mem_ready && mem_rdata[31:30] != OWN_ENGINE) begin
            sta_set[STA_NODESC] = 1'b1;
            sta_set[STA_INTR]   = 1'b1;
        end
        if (pk_take && pk_count == '0) sta_set[STA_EARLY] = 1'b1;
        if (st_q == ST_PUT_STAT && mem_ready) begin
            sta_set[STA_GOOD] = 1'b1;
            sta_set[STA_INTR] = 1'b1;
            sta_set[STA_PTLE] = ptle_q;
        end
    end

    rxwb_status u_sta (
        .clk   (clk),
        .rst   (rst),
        .set_i (sta_set),
        .clr_i (sta_clr),
        .en_i  (irq_en),
        .sta_o (rx_status),
        .irq_o (rx_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            ctx_q     <= '0;
            cur_q     <= '0;
            off_q     <= '0;
            len_q     <= '0;
            ptle_q    <= 1'b0;
            started_q <= 1'b0;
            drop_q    <= 1'b0;
            mid_q     <= 1'b0;
            poll_q    <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cfg_rx_en) begin
                        if (!started_q) cur_q <= cfg_list_base;
                        started_q <= 1'b1;
                        st_q      <= ST_GET_STAT;
                    end
                end
                ST_GET_STAT: begin
                    if (mem_ready) begin
                        if (mem_rdata[31:30] == OWN_ENGINE) begin
                            st_q <= ST_GET_BUF;
                        end else begin
                            st_q   <= ST_NODESC;
                            poll_q <= 1'b0;
                            mid_q  <= 1'b0;
                        end
                    end
                end
                ST_GET_BUF: begin
                    if (mem_ready) begin
                        ctx_q.buf_addr <= mem_rdata;
                        st_q           <= ST_GET_NEXT;
                    end
                end
                ST_GET_NEXT: begin
                    if (mem_ready) begin
                        ctx_q.next_addr <= mem_rdata;
                        off_q           <= '0;
                        drop_q          <= 1'b0;
                        st_q            <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (pk_flush) begin
                        if (drop_now) drop_q <= 1'b1;
                        else          off_q  <= off_q + OFS_BUF;
                        if (pk_plast) begin
                            if (drop_now) begin
                                drop_q <= 1'b0;
                                off_q  <= '0;
                            end else begin
                                len_q  <= pk_count;
                                ptle_q <= pk_over;
                                st_q   <= ST_PUT_STAT;
                            end
                        end
                    end
                end
                ST_PUT_STAT: begin
                    if (mem_ready) begin
                        cur_q <= ctx_q.next_addr;
                        st_q  <= ST_IDLE;
                    end
                end
                ST_NODESC: begin
                    if (rx_poll) poll_q <= 1'b1;
                    if (take) mid_q <= !rx_last;
                    if (poll_q && !mid_q && !take) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cur_desc = cur_q;
endmodule

// File: rtl/rxwb_checker.sv
module rxwb_checker
    import rxwb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_long_ok,
    input logic [STA_W-1:0]  irq_en,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] cur_desc,
    input logic [STA_W-1:0]  rx_status,
    input logic              rx_irq,
    input logic              in_nodesc,
    input logic              started
);
    logic wb_done;
    assign wb_done = mem_req && mem_we && mem_ready && (mem_addr == cur_desc);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (rx_status == '0 && cur_desc == '0 && !rx_irq));

    p_wb_cpu_owned_r3: assert property (@(posedge clk) disable iff (rst)
        wb_done |-> (mem_wdata[31:30] == OWN_CPU && mem_wdata[20]));

    p_cur_moves_on_wb_r5: assert property (@(posedge clk) disable iff (rst)
        (started && !wb_done) |=> $stable(cur_desc));

    p_long_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
        (wb_done && mem_wdata[19]) |-> cfg_long_ok);

    p_no_access_nodesc_r8: assert property (@(posedge clk) disable iff (rst)
        in_nodesc |-> !mem_req);

    p_irq_needs_enabled_bit_r10: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (|(rx_status & irq_en)));
endmodule

bind rxwb_engine rxwb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_long_ok (cfg_long_ok),
    .irq_en      (irq_en),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .cur_desc    (cur_desc),
    .rx_status   (rx_status),
    .rx_irq      (rx_irq),
    .in_nodesc   (st_q == rxwb_pkg::ST_NODESC),
    .started     (started_q)
);

// File: tb/sim_rxwb_engine.sv
module sim_rxwb_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_list_base = 32'h100;
    logic        cfg_rx_en = 1'b0;
    logic        cfg_long_ok = 1'b0;
    logic        rx_poll = 1'b0;
    logic [15:0] irq_en = 16'h0001;
    logic [15:0] sta_clr = 16'h0000;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_desc;
    logic [15:0] rx_status;
    logic        rx_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] mem     [0:1023];
    logic [31:0] exp_mem [0:1023];

    always #5 clk = ~clk;

    rxwb_engine u0 (.*);

    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk)
        if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_ready <= ((cyc % 3) != 0);
    end

    // Per-cycle model of the interrupt rule (R10)
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (rx_irq !== |(rx_status & irq_en)) begin
                fails++;
                $display("FAIL R10 irq got %b exp %b", rx_irq, |(rx_status & irq_en));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got running exp done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [7:0] pat(int i, int seed);
        return 8'((i * 7 + seed * 13) & 255);
    endfunction

    task automatic check32(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic model_frame(int bufa, int len, int seed);
        for (int i = 0; i < len; i++) begin
            int w = (bufa + i) >> 2;
            int b = (bufa + i) & 3;
            if (b == 0) exp_mem[w] = 32'h0;
            exp_mem[w][b*8 +: 8] = pat(i, seed);
        end
    endtask

    task automatic check_region(string tag, int lo, int hi);
        int bad = 0;
        logic [31:0] g = 0, e = 0;
        for (int w = lo >> 2; w < (hi >> 2); w++)
            if (mem[w] !== exp_mem[w] && bad == 0) begin
                bad = 1; g = mem[w]; e = exp_mem[w];
            end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s region %h got %h exp %h", tag, lo, g, e);
        end
    endtask

    task automatic send(int len, int seed, bit poll_mid);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(i, seed);
            rx_last  = (i == len - 1);
            rx_poll  = poll_mid && (i == len / 2);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        rx_poll  = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); sta_clr = 16'hFFFF;
        @(negedge clk); sta_clr = 16'h0000;
    endtask

    task automatic pulse_poll();
        @(negedge clk); rx_poll = 1'b1;
        @(negedge clk); rx_poll = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic set_word(int addr, logic [31:0] v);
        mem[addr >> 2] = v;
        exp_mem[addr >> 2] = v;
    endtask

    initial begin
        for (int w = 0; w < 1024; w++) begin mem[w] = 0; exp_mem[w] = 0; end
        set_word(32'h100, 32'h8000_0000); set_word(32'h104, 32'h200); set_word(32'h10C, 32'h110);
        set_word(32'h110, 32'h8000_0000); set_word(32'h114, 32'h400); set_word(32'h11C, 32'h120);
        set_word(32'h120, 32'h0000_0000); set_word(32'h124, 32'h800); set_word(32'h12C, 32'h100);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check32("R1 cur_desc", cur_desc, 0);
        check32("R1 status", {16'h0, rx_status}, 0);
        check32("R1 irq/ready", {30'h0, rx_irq, rx_ready}, 0);

        cfg_rx_en = 1'b1;
        repeat (12) @(negedge clk);
        check32("R2 cur_desc loaded from base", cur_desc, 32'h100);

        // Frame A: 68 bytes, poll pulse in the middle (R9)
        send(68, 1, 1'b1);
        model_frame(32'h200, 68, 1);
        exp_mem[32'h100 >> 2] = 32'h0011_0044;
        check_region("R4 R9 buffer A", 32'h200, 32'h250);
        check32("R3 wb word A", mem[32'h100 >> 2], 32'h0011_0044);
        check32("R5 cur after A", cur_desc, 32'h110);
        check32("R6 status after A", {16'h0, rx_status}, 32'h0211);
        check32("R10 irq after A", {31'h0, rx_irq}, 1);

        pulse_clr();
        irq_en = 16'h0000;
        @(negedge clk);
        check32("R10 status cleared", {16'h0, rx_status}, 0);

        // Frame B: 7 bytes, partial last word; next descriptor CPU-owned
        send(7, 2, 1'b0);
        model_frame(32'h400, 7, 2);
        exp_mem[32'h110 >> 2] = 32'h0010_0007;
        check_region("R4 buffer B partial", 32'h400, 32'h408);
        check32("R3 wb word B no intr bit", mem[32'h110 >> 2], 32'h0010_0007);
        check32("R5 cur after B", cur_desc, 32'h120);
        check32("R8 status nodesc", {16'h0, rx_status}, 32'h0611);
        check32("R10 irq masked", {31'h0, rx_irq}, 0);
        irq_en = 16'h0400;
        @(negedge clk);
        check32("R10 irq on nodesc", {31'h0, rx_irq}, 1);

        // Frame C discarded while no descriptor
        send(12, 9, 1'b0);
        check_region("R8 no store while unavailable", 32'h800, 32'h810);
        check32("R8 desc C untouched", mem[32'h120 >> 2], 0);
        check32("R8 cur held", cur_desc, 32'h120);

        // Frame D: 1600 bytes with long frames allowed
        pulse_clr();
        irq_en = 16'h0001;
        cfg_long_ok = 1'b1;
        set_word(32'h120, 32'h8000_0000);
        pulse_poll();
        send(1600, 3, 1'b0);
        model_frame(32'h800, 1600, 3);
        exp_mem[32'h120 >> 2] = 32'h0019_0640;
        check_region("R7 buffer D", 32'h800, 32'h800 + 1600);
        check32("R7 wb word D", mem[32'h120 >> 2], 32'h0019_0640);
        check32("R5 cur after D", cur_desc, 32'h100);
        check32("R7 status D", {16'h0, rx_status}, 32'h0619);

        // Frame E: 1519 bytes, long frames refused -> dropped
        pulse_clr();
        cfg_long_ok = 1'b0;
        set_word(32'h100, 32'h8000_0000);
        pulse_poll();
        send(1519, 4, 1'b0);
        check32("R7 dropped desc untouched", mem[32'h100 >> 2], 32'h8000_0000);
        check32("R7 cur held on drop", cur_desc, 32'h100);
        check32("R6 early only on drop", {16'h0, rx_status}, 32'h0200);

        // Frame F: 1518 bytes, largest normal frame
        send(1518, 5, 1'b0);
        model_frame(32'h200, 1518, 5);
        exp_mem[32'h100 >> 2] = 32'h0011_05EE;
        check_region("R7 buffer F", 32'h200, 32'h200 + 1516);
        check32("R3 wb word F", mem[32'h100 >> 2], 32'h0011_05EE);
        check32("R5 cur after F", cur_desc, 32'h110);
        check32("R8 status F", {16'h0, rx_status}, 32'h0611);
        check_region("R2 descriptor words", 32'h100, 32'h130);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule